// File: doc/BRIEF.md
# Asymmetric Edge Delay Filter

The block takes one asynchronous logic level and produces a qualified copy of it. A rising input edge reaches the output only after the input has stayed high for a programmed time. A falling edge reaches the output only after the input has stayed low for a separately programmed time. Because the two delays are independent, the block can lengthen or shorten output pulses and remove transients that are shorter than the active timeout. Time is measured by counting pulses of an external 1 ms tick strobe, so the system clock frequency does not matter.

An 8-bit configuration byte holds two 4-bit delay codes, one for each edge. Each code selects one of sixteen fixed delays between 0 and 500 ms. The input passes through a two-stage synchroniser before it is evaluated. There is no data stream here, so every pin is a plain level or strobe, with no valid/ready handshake and no back-pressure. The configuration is sampled when an edge is first detected, so writing a new byte affects the next edge and leaves the pending one unchanged.

Top module: `asym_edge_qualifier`

## Requirements
- R1: A synchronous reset drives `dout` low, clears the synchroniser and stops any timer. After reset is released, `dout` stays low for at least the first three clock edges.
- R2: `din` passes through a two-flop synchroniser. With a rise code of 0, `dout` goes high at the third rising clock edge after `din` goes high. With a fall code of 0, `dout` goes low at the third rising clock edge after `din` goes low.
- R3: `cfg[3:0]` is the rise delay code and `cfg[7:4]` is the fall delay code. Both use the same table, with codes 0 to 15 mapping to 0, 1, 5, 10, 20, 30, 50, 75, 100, 150, 200, 250, 300, 350, 400 and 500 ticks.
- R4: For a nonzero rise code of N ticks, `dout` rises on the clock edge of the N-th tick cycle while the synchronised input is high. The tick in the cycle that detects the edge does not count.
- R5: If the synchronised input returns low before the rise count completes, no output edge is produced and the count is cleared. A later pulse needs the full N ticks again.
- R6: With a fall code of 0, a falling input edge is passed to `dout` without any added delay.
- R7: For a nonzero fall code of M ticks, `dout` falls on the clock edge of the M-th tick cycle while the synchronised input is low and `dout` is high.
- R8: While `dout` is low, a falling input edge starts no fall timer. Ticks that arrive while the input is low leave no count behind for the next rise.
- R9: If the input rises again while a fall count is running, the count is cleared and `dout` stays high. The next falling edge needs the full M ticks.
- R10: The delay codes are captured when an edge is detected. A change to `cfg` while a count is pending does not alter that count, and the new value applies to the next edge.
- R11: If the input reverts in the same cycle as the tick that would complete a count, the reversion wins and no output edge is produced.
- R12: Counts advance only in cycles where `tick_ms` is high. Without ticks, a nonzero delay never completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle strobe each millisecond |
| din | input | 1 | Asynchronous level to be qualified |
| cfg | input | 8 | Delay codes: rise in [3:0], fall in [7:4] |
| dout | output | 1 | Qualified, delayed level |

## Verification
The two functions that can meet in one cycle are the completion of a pending count by a tick and the cancellation of that count by an input reversion. The bench lowers `din` so that the synchronised level reaches the control logic in exactly the cycle where the final tick is strobed. It then checks that `dout` never rises. It repeats the same stimulus with the tick one cycle earlier and checks that the edge is then produced, which confirms the alignment and shows that cancellation takes priority.

// File: rtl/edq_pkg.sv
package edq_pkg;

  localparam int CODE_W = 4;
  localparam int CNT_W  = 9;

  typedef enum logic [1:0] {
    ST_LOW       = 2'd0,
    ST_RISE_WAIT = 2'd1,
    ST_HIGH      = 2'd2,
    ST_FALL_WAIT = 2'd3
  } edq_state_e;

  // Delay code to tick count (1 tick = 1 ms)
  function automatic logic [CNT_W-1:0] edq_code_ticks(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] t;
    case (code)
      4'd0:    t = 9'd0;
      4'd1:    t = 9'd1;
      4'd2:    t = 9'd5;
      4'd3:    t = 9'd10;
      4'd4:    t = 9'd20;
      4'd5:    t = 9'd30;
      4'd6:    t = 9'd50;
      4'd7:    t = 9'd75;
      4'd8:    t = 9'd100;
      4'd9:    t = 9'd150;
      4'd10:   t = 9'd200;
      4'd11:   t = 9'd250;
      4'd12:   t = 9'd300;
      4'd13:   t = 9'd350;
      4'd14:   t = 9'd400;
      default: t = 9'd500;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/edq_sync.sv
module edq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edq_delay_lut.sv
module edq_delay_lut
  import edq_pkg::*;
#(
  parameter int LUT_CODE_W = CODE_W,
  parameter int LUT_CNT_W  = CNT_W
) (
  input  logic [LUT_CODE_W-1:0] code,
  output logic [LUT_CNT_W-1:0]  ticks
);
  assign ticks = LUT_CNT_W'(edq_code_ticks(CODE_W'(code)));
endmodule

// File: rtl/edq_edge_timer.sv
module edq_edge_timer
  import edq_pkg::*;
#(
  parameter int TMR_CNT_W = CNT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 lvl,
  input  logic [TMR_CNT_W-1:0] rise_ticks,
  input  logic [TMR_CNT_W-1:0] fall_ticks,
  output logic                 q
);
  edq_state_e           state, state_n;
  logic [TMR_CNT_W-1:0] cnt, cnt_n;
  logic [TMR_CNT_W-1:0] tgt, tgt_n;
  logic [TMR_CNT_W-1:0] cnt_inc;
  logic                 done;

  assign cnt_inc = cnt + 1'b1;
  assign done    = tick && (cnt_inc == tgt);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    tgt_n   = tgt;
    unique case (state)
      ST_LOW: begin
        if (lvl) begin
          cnt_n = '0;
          if (rise_ticks == '0) begin
            state_n = ST_HIGH;
          end else begin
            state_n = ST_RISE_WAIT;
            tgt_n   = rise_ticks;
          end
        end
      end
      ST_RISE_WAIT: begin
        if (!lvl) begin
          state_n = ST_LOW;
          cnt_n   = '0;
        end else if (done) begin
          state_n = ST_HIGH;
          cnt_n   = '0;
        end else if (tick) begin
          cnt_n = cnt_inc;
        end
      end
      ST_HIGH: begin
        if (!lvl) begin
          cnt_n = '0;
          if (fall_ticks == '0) begin
            state_n = ST_LOW;
          end else begin
            state_n = ST_FALL_WAIT;
            tgt_n   = fall_ticks;
          end
        end
      end
      ST_FALL_WAIT: begin
        if (lvl) begin
          state_n = ST_HIGH;
          cnt_n   = '0;
        end else if (done) begin
          state_n = ST_LOW;
          cnt_n   = '0;
        end else if (tick) begin
          cnt_n = cnt_inc;
        end
      end
      default: begin
        state_n = ST_LOW;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOW;
      cnt   <= '0;
      tgt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      tgt   <= tgt_n;
    end
  end

  assign q = (state == ST_HIGH) || (state == ST_FALL_WAIT);
endmodule

// File: rtl/asym_edge_qualifier.sv
module asym_edge_qualifier
  import edq_pkg::*;
#(
  parameter int EQ_CODE_W = CODE_W,
  parameter int EQ_CNT_W  = CNT_W,
  parameter int SYNC_LEN  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_ms,
  input  logic                   din,
  input  logic [2*EQ_CODE_W-1:0] cfg,
  output logic                   dout
);
  localparam int NUM_EDGES = 2;

  logic                lvl_s;
  logic [EQ_CNT_W-1:0] edge_ticks [NUM_EDGES];

  edq_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (lvl_s)
  );

  // index 0: rising-edge code, index 1: falling-edge code
  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_lut
    edq_delay_lut #(
      .LUT_CODE_W (EQ_CODE_W),
      .LUT_CNT_W  (EQ_CNT_W)
    ) u_lut (
      .code  (cfg[e*EQ_CODE_W +: EQ_CODE_W]),
      .ticks (edge_ticks[e])
    );
  end

  edq_edge_timer #(.TMR_CNT_W(EQ_CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_ms),
    .lvl        (lvl_s),
    .rise_ticks (edge_ticks[0]),
    .fall_ticks (edge_ticks[1]),
    .q          (dout)
  );
endmodule

// File: rtl/asym_edge_qualifier_chk.sv
module asym_edge_qualifier_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_ms,
  input logic       din,
  input logic [7:0] cfg,
  input logic       dout
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_EARLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd3) |-> !dout);  // R1

  AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $rose(dout)) |-> $past(din, 3));  // R4

  AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $fell(dout)) |-> !$past(din, 3));  // R7

  AST_UNTICKED_RISE: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $rose(dout) && !$past(tick_ms)) |-> ($past(cfg[3:0]) == 4'd0));  // R12

  AST_UNTICKED_FALL: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $fell(dout) && !$past(tick_ms)) |-> ($past(cfg[7:4]) == 4'd0));  // R6
endmodule

bind asym_edge_qualifier asym_edge_qualifier_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_ms (tick_ms),
  .din     (din),
  .cfg     (cfg),
  .dout    (dout)
);

// File: tb/asym_edge_qualifier_tb.sv
module asym_edge_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b0;
  logic       din = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       dout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  asym_edge_qualifier u_dut (
    .clk     (clk),
    .rst     (rst),
    .tick_ms (tick_ms),
    .din     (din),
    .cfg     (cfg),
    .dout    (dout)
  );

  // {rise code, fall code, ticks held high}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    20'h00_000, 20'h10_001, 20'h21_004, 20'h22_005,
    20'h34_00C, 20'h80_063, 20'h79_050, 20'hFF_1F4
  };

  function automatic int spec_ticks(input logic [3:0] c);
    int t;
    case (c)
      4'd0: t = 0;    4'd1: t = 1;    4'd2: t = 5;    4'd3: t = 10;
      4'd4: t = 20;   4'd5: t = 30;   4'd6: t = 50;   4'd7: t = 75;
      4'd8: t = 100;  4'd9: t = 150;  4'd10: t = 200; 4'd11: t = 250;
      4'd12: t = 300; 4'd13: t = 350; 4'd14: t = 400; default: t = 500;
    endcase
    return t;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic run_vec(input int v);
    logic [3:0] rc, fc;
    int hold, rd, fd, rise_at, fall_at;
    rc = VEC[v][19:16];
    fc = VEC[v][15:12];
    hold = int'(VEC[v][11:0]);
    rd = spec_ticks(rc);
    fd = spec_ticks(fc);
    @(negedge clk);
    cfg = {fc, rc};
    din = 1'b1;
    idle(5);
    rise_at = dout ? 0 : -1;
    for (int i = 0; i < hold; i++) begin
      pulse_tick();
      if (dout && rise_at < 0) rise_at = i + 1;
    end
    // R3 R4: rise after exactly the tabled tick count, or never
    chk_int("R3 R4 rise tick", rise_at, (hold >= rd) ? rd : -1);
    idle(2);
    din = 1'b0;
    idle(5);
    if (rise_at >= 0) begin
      if (fd == 0) begin
        chk_bit("R6 zero fall", dout, 1'b0);
      end else begin
        fall_at = -1;
        for (int i = 0; i < fd + 2; i++) begin
          pulse_tick();
          if (!dout && fall_at < 0) fall_at = i + 1;
        end
        chk_int("R3 R7 fall tick", fall_at, fd);
      end
    end else begin
      chk_bit("R5 no rise", dout, 1'b0);
    end
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, synchroniser cleared
    din = 1'b1;
    idle(4);
    chk_bit("R1 in reset", dout, 1'b0);
    rst = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk_bit("R1 after release", dout, 1'b0);
    @(negedge clk);
    chk_bit("R2 third edge", dout, 1'b1);
    din = 1'b0;
    idle(5);

    // vector table
    for (int v = 0; v < NV; v++) run_vec(v);

    // R2: two-flop latency, both edges with zero codes
    cfg = 8'h00;
    @(negedge clk) din = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk_bit("R2 rise after two edges", dout, 1'b0);
    @(negedge clk);
    chk_bit("R2 rise at third edge", dout, 1'b1);
    din = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk_bit("R2 fall after two edges", dout, 1'b1);
    @(negedge clk);
    chk_bit("R2 fall at third edge", dout, 1'b0);

    // R5: cancelled rise clears the count
    cfg = 8'h02;
    din = 1'b1; idle(5);
    repeat (3) pulse_tick();
    din = 1'b0; idle(5);
    din = 1'b1; idle(5);
    repeat (4) pulse_tick();
    chk_bit("R5 count restarted", dout, 1'b0);
    pulse_tick();
    chk_bit("R5 full count rises", dout, 1'b1);
    din = 1'b0; idle(5);

    // R8: low output, falling input arms nothing
    cfg = 8'h03;
    din = 1'b1; idle(5);
    repeat (2) pulse_tick();
    din = 1'b0; idle(5);
    repeat (10) pulse_tick();
    chk_bit("R8 stays low", dout, 1'b0);
    din = 1'b1; idle(5);
    repeat (9) pulse_tick();
    chk_bit("R8 no leftover count", dout, 1'b0);
    pulse_tick();
    chk_bit("R8 rise after full count", dout, 1'b1);
    din = 1'b0; idle(5);

    // R9: rise during fall count cancels it
    cfg = 8'h40;
    din = 1'b1; idle(5);
    chk_bit("R9 high", dout, 1'b1);
    din = 1'b0; idle(5);
    repeat (15) pulse_tick();
    din = 1'b1; idle(5);
    repeat (30) pulse_tick();
    chk_bit("R9 stays high", dout, 1'b1);
    din = 1'b0; idle(5);
    repeat (19) pulse_tick();
    chk_bit("R9 fall count restarted", dout, 1'b1);
    pulse_tick();
    chk_bit("R9 fall after full count", dout, 1'b0);

    // R10: codes captured at edge detection
    cfg = 8'h02;
    din = 1'b1; idle(5);
    repeat (2) pulse_tick();
    cfg = 8'h01;
    repeat (2) pulse_tick();
    chk_bit("R10 pending count unchanged", dout, 1'b0);
    pulse_tick();
    chk_bit("R10 old code completes", dout, 1'b1);
    din = 1'b0; idle(5);
    din = 1'b1; idle(5);
    pulse_tick();
    chk_bit("R10 new code on next edge", dout, 1'b1);
    din = 1'b0; idle(5);

    // R11: reversion and final tick in the same cycle
    cfg = 8'h01;
    din = 1'b1; idle(5);
    @(negedge clk) din = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
    idle(3);
    chk_bit("R11 reversion wins", dout, 1'b0);
    din = 1'b1; idle(5);
    @(negedge clk) din = 1'b0;
    @(posedge clk);
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
    chk_bit("R11 tick one cycle earlier rises", dout, 1'b1);
    idle(3);
    chk_bit("R6 then falls at once", dout, 1'b0);

    // R12: no tick, no progress
    cfg = 8'h01;
    din = 1'b1;
    idle(50);
    chk_bit("R12 no ticks no rise", dout, 1'b0);
    pulse_tick();
    chk_bit("R12 first tick rises", dout, 1'b1);

    // R1: reset while high
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk_bit("R1 mid-run reset", dout, 1'b0);
    rst = 1'b0;
    din = 1'b0;
    idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule